// File: doc/BRIEF.md
# Petri Net Transition Element

This block stands for one transition of a Petri net that has been mapped directly into logic. Each place element of the net reports a single presence bit: whether it currently holds at least one token. The transition collects these bits from its input places, sorted by the kind of arc that connects them. A consuming arc requires a token and removes it when the transition fires. A test arc requires a token and leaves it in place. An inhibitor arc requires the place to be empty. A net-wide synchronization enable gates every firing.

When all arc conditions hold and the synchronization enable is high, the element raises its registered fire strobe on the next clock edge. The place elements use that strobe to step their token counters: they decrement each consuming-arc input place and increment each output place. The strobe comes from a JK-style register. The enable logic drives its set and clear inputs. The register also clears itself after one cycle. This leaves the places one cycle to update their presence bits before the transition can fire again.

Each arc count is a separate parameter. A count of zero removes that group from the enable condition. In that case the group's one-bit input is a placeholder and has no effect.

Top module: `pn_transition`

## Requirements
- R1: A high `rst` sampled at a clock edge makes `fire` low after that edge, whatever the other inputs are.
- R2: If any bit of `consumeMarks` is 0, `fire` is low after the next edge.
- R3: If any bit of `testMarks` is 0, `fire` is low after the next edge.
- R4: If any bit of `inhibMarks` is 1, `fire` is low after the next edge.
- R5: If `syncEn` is 0, `fire` is low after the next edge.
- R6: If `fire` is low and these inputs are sampled at an edge with `rst` low, `fire` is high after that edge:
  - all consuming and test bits are 1,
  - all inhibitor bits are 0,
  - `syncEn` is 1.
- R7: `fire` is never high for two consecutive cycles. Under a constant enable it alternates high and low.
- R8: A group whose count parameter is 0 is always satisfied. The value on its one-bit placeholder input has no effect on `fire`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| syncEn | input | 1 | Net-wide synchronization enable |
| consumeMarks | input | max(NUM_CONSUME,1) | Presence bits of places on consuming arcs |
| testMarks | input | max(NUM_TEST,1) | Presence bits of places on test arcs |
| inhibMarks | input | max(NUM_INHIB,1) | Presence bits of places on inhibitor arcs |
| fire | output | 1 | One-cycle firing strobe |

## Verification
Each arc group is exercised on its own. The missing-token cases clear one consuming bit at a time, then one test bit at a time, and the present-token case sets one inhibitor bit at a time. These runs show that every single bit can block firing by itself, and that a missing token on a test arc blocks firing the same way a missing token on a consuming arc does. A fully enabled pattern is then held for many cycles, which shows the alternating one-cycle strobe apart from a level. Dropping `syncEn` and asserting reset in the middle of that pattern confirm that both gates take effect. A second instance with all counts at zero is driven with its placeholder bits set to values that would otherwise block firing, which confirms that empty groups are ignored.

// File: rtl/pn_transition_pkg.sv
package pn_transition_pkg;

  // Commands from the enable control to the fire register
  typedef struct packed {
    logic setFire;   // J input
    logic clrFire;   // K input
  } fireCmd_t;

  function automatic int unsigned groupWidth(int unsigned n);
    return (n == 0) ? 1 : n;
  endfunction

endpackage

// File: rtl/pn_enable_ctrl.sv
module pn_enable_ctrl
  import pn_transition_pkg::*;
#(
  parameter int unsigned NUM_CONSUME = 3,
  parameter int unsigned NUM_TEST    = 2,
  parameter int unsigned NUM_INHIB   = 2,
  localparam int unsigned CW = groupWidth(NUM_CONSUME),
  localparam int unsigned TW = groupWidth(NUM_TEST),
  localparam int unsigned IW = groupWidth(NUM_INHIB)
) (
  input  logic          syncEn,
  input  logic [CW-1:0] consumeMarks,
  input  logic [TW-1:0] testMarks,
  input  logic [IW-1:0] inhibMarks,
  input  logic          fireNow,
  output logic          enabled,
  output fireCmd_t      cmd
);

  logic consumeOk;
  logic testOk;
  logic inhibOk;

  // An empty group imposes no condition; its placeholder bit is ignored.
  generate
    if (NUM_CONSUME == 0) begin : gConsumeNone
      logic unusedC;
      assign unusedC   = consumeMarks[0];
      assign consumeOk = 1'b1;
    end else begin : gConsumeAll
      assign consumeOk = &consumeMarks;
    end

    if (NUM_TEST == 0) begin : gTestNone
      logic unusedT;
      assign unusedT = testMarks[0];
      assign testOk  = 1'b1;
    end else begin : gTestAll
      assign testOk = &testMarks;
    end

    if (NUM_INHIB == 0) begin : gInhibNone
      logic unusedI;
      assign unusedI = inhibMarks[0];
      assign inhibOk = 1'b1;
    end else begin : gInhibAll
      assign inhibOk = ~(|inhibMarks);
    end
  endgenerate

  assign enabled = syncEn & consumeOk & testOk & inhibOk;

  // Set only from idle; clear whenever high or no longer enabled.
  always_comb begin
    cmd.setFire = enabled & ~fireNow;
    cmd.clrFire = fireNow | ~enabled;
  end

endmodule

// File: rtl/pn_fire_reg.sv
module pn_fire_reg
  import pn_transition_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  fireCmd_t cmd,
  output logic     fireQ
);

  always_ff @(posedge clk) begin
    if (rst) begin
      fireQ <= 1'b0;
    end else begin
      unique case ({cmd.setFire, cmd.clrFire})
        2'b10:   fireQ <= 1'b1;
        2'b01:   fireQ <= 1'b0;
        2'b11:   fireQ <= ~fireQ;
        default: fireQ <= fireQ;
      endcase
    end
  end

  // R7
  no_double_fire_chk: assert property (@(posedge clk) disable iff (rst)
    fireQ |=> !fireQ);

endmodule

// File: rtl/pn_transition.sv
module pn_transition
  import pn_transition_pkg::*;
#(
  parameter int unsigned NUM_CONSUME = 3,
  parameter int unsigned NUM_TEST    = 2,
  parameter int unsigned NUM_INHIB   = 2,
  localparam int unsigned CW = groupWidth(NUM_CONSUME),
  localparam int unsigned TW = groupWidth(NUM_TEST),
  localparam int unsigned IW = groupWidth(NUM_INHIB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          syncEn,
  input  logic [CW-1:0] consumeMarks,
  input  logic [TW-1:0] testMarks,
  input  logic [IW-1:0] inhibMarks,
  output logic          fire
);

  fireCmd_t fireCmd;
  logic     enabled;

  pn_enable_ctrl #(
    .NUM_CONSUME(NUM_CONSUME),
    .NUM_TEST   (NUM_TEST),
    .NUM_INHIB  (NUM_INHIB)
  ) uCtrl (
    .syncEn      (syncEn),
    .consumeMarks(consumeMarks),
    .testMarks   (testMarks),
    .inhibMarks  (inhibMarks),
    .fireNow     (fire),
    .enabled     (enabled),
    .cmd         (fireCmd)
  );

  pn_fire_reg uFire (
    .clk  (clk),
    .rst  (rst),
    .cmd  (fireCmd),
    .fireQ(fire)
  );

  // R5
  sync_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !syncEn |=> !fire);

  // R6
  fire_follows_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (enabled && !fire) |=> fire);

  generate
    if (NUM_CONSUME != 0) begin : gChkC
      // R2
      consume_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !(&consumeMarks) |=> !fire);
    end
    if (NUM_TEST != 0) begin : gChkT
      // R3
      test_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !(&testMarks) |=> !fire);
    end
    if (NUM_INHIB != 0) begin : gChkI
      // R4
      inhib_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (|inhibMarks) |=> !fire);
    end
  endgenerate

endmodule

// File: tb/tb_pn_transition.sv
module tb_pn_transition;

  localparam int NC = 3;
  localparam int NT = 2;
  localparam int NI = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic syncEn = 1'b0;
  logic [NC-1:0] cMarks = '0;
  logic [NT-1:0] tMarks = '0;
  logic [NI-1:0] iMarks = '0;
  logic fire;

  logic zC = 1'b0, zT = 1'b0, zI = 1'b1;
  logic fireZ;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";
  bit expFire  = 1'b0;
  bit expFireZ = 1'b0;

  always #4 clk = ~clk;

  pn_transition #(.NUM_CONSUME(NC), .NUM_TEST(NT), .NUM_INHIB(NI)) dut (
    .clk(clk), .rst(rst), .syncEn(syncEn),
    .consumeMarks(cMarks), .testMarks(tMarks), .inhibMarks(iMarks),
    .fire(fire)
  );

  // R8: every group empty; placeholders driven to blocking-looking values
  pn_transition #(.NUM_CONSUME(0), .NUM_TEST(0), .NUM_INHIB(0)) dutZero (
    .clk(clk), .rst(rst), .syncEn(syncEn),
    .consumeMarks(zC), .testMarks(zT), .inhibMarks(zI),
    .fire(fireZ)
  );

  // Behavioural reference, counting tokens with integers
  function automatic bit refEnabled();
    int have = 0;
    int blocked = 0;
    for (int k = 0; k < NC; k++) if (cMarks[k]) have++;
    for (int k = 0; k < NT; k++) if (tMarks[k]) have++;
    for (int k = 0; k < NI; k++) if (iMarks[k]) blocked++;
    return (have == NC + NT) && (blocked == 0) && syncEn;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      expFire  <= 1'b0;
      expFireZ <= 1'b0;
    end else begin
      expFire  <= expFire  ? 1'b0 : refEnabled();
      expFireZ <= expFireZ ? 1'b0 : syncEn;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: fire=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Compare on every cycle, away from the active edge
  always @(negedge clk) begin
    check(tag, fire, expFire);
    check("R8", fireZ, expFireZ);
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  initial begin
    #40000;
    fails++;
    checks++;
    $display("FAIL watchdog: run=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk); #1;
    tick(2);
    // R1: reset state
    tag = "R1";
    check("R1", fire, 1'b0);
    rst = 1'b0;
    tick(1);

    // R2: each consuming bit missing alone
    tag = "R2";
    syncEn = 1'b1; tMarks = '1; iMarks = '0;
    for (int k = 0; k < NC; k++) begin
      cMarks = '1; cMarks[k] = 1'b0;
      tick(3);
      check("R2", fire, 1'b0);
    end

    // R3: each test bit missing alone
    tag = "R3";
    cMarks = '1;
    for (int k = 0; k < NT; k++) begin
      tMarks = '1; tMarks[k] = 1'b0;
      tick(3);
      check("R3", fire, 1'b0);
    end

    // R4: each inhibitor bit set alone
    tag = "R4";
    tMarks = '1;
    for (int k = 0; k < NI; k++) begin
      iMarks = '0; iMarks[k] = 1'b1;
      tick(3);
      check("R4", fire, 1'b0);
    end

    // R5: everything satisfied but synchronization low
    tag = "R5";
    iMarks = '0; syncEn = 1'b0;
    tick(3);
    check("R5", fire, 1'b0);

    // R6: enable appears, fire after one edge
    tag = "R6";
    syncEn = 1'b1;
    tick(1);
    check("R6", fire, 1'b1);

    // R7: held enable gives an alternating strobe
    tag = "R7";
    tick(1);
    check("R7", fire, 1'b0);
    tick(1);
    check("R7", fire, 1'b1);
    tick(5);

    // R1: reset while enabled
    tag = "R1";
    rst = 1'b1;
    tick(1);
    check("R1", fire, 1'b0);
    tick(1);
    check("R1", fire, 1'b0);
    rst = 1'b0;
    tag = "R6";
    tick(1);
    check("R6", fire, 1'b1);

    // Mixed patterns toggling between blocked and enabled
    tag = "R7";
    for (int n = 0; n < 24; n++) begin
      cMarks = (n % 5 == 0) ? 3'b101 : 3'b111;
      iMarks = (n % 7 == 3) ? 2'b10 : 2'b00;
      syncEn = (n % 6 != 4);
      zC = n[0]; zT = n[1]; zI = n[2];
      tick(1);
    end

    // R8: placeholders toggled with synchronization held high
    tag = "R8";
    syncEn = 1'b1; cMarks = '1; tMarks = '1; iMarks = '0;
    zC = 1'b0; zT = 1'b0; zI = 1'b1;
    tick(4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule